// File: doc/BRIEF.md
# Fault-Protected Finite-Field Multiplier

This block multiplies two elements of the binary extension field GF(2^m). Elements use polynomial basis, and every product is reduced modulo a fixed irreducible polynomial. The datapath is a pipeline of m identical cells. Each cell takes one bit of the second operand, starting with the most significant bit, and performs one shift-reduce-accumulate step. A new operation can start on every clock.

Each cell also carries a predicted parity next to its data. The predicted parity is updated from the operand-A parity and from the accumulator's top bit. At the output, the prediction is compared with the actual parity of the product. If they disagree, the error flag rises and the product is XORed with the current state of a free-running maximal-length shift-register generator. A corrupted result therefore never leaves the block in clear form.

A test input can flip one selectable accumulator bit inside one selectable cell. This lets a bench confirm that every single-bit fault site is caught.

Top module: `gfm_guard_mul`

## Requirements
- R1: With no fault injected, `prod_out` equals the product of `a_in` and `b_in` in GF(2^m), reduced by x^m + POLY (default x^8+x^4+x^3+x+1, POLY = 8'h1B). Example: 8'h57 times 8'h83 gives 8'hC1.
- R2: With no fault injected, `err_out` stays low on every valid output.
- R3: `start` is sampled on a rising edge. `prod_vld` is high for exactly one cycle, M+1 rising edges later. `err_out` is never high while `prod_vld` is low.
- R4: Operations may be started on consecutive cycles. Results come out in issue order, one per cycle, each one correct.
- R5: When `flt_en` is high, cell `flt_stage` (0 = the cell that consumes `b_in` bit M-1) XORs a one at position `flt_bit` into its accumulator output. Any such single-bit fault on an operation sets `err_out` on that operation's result.
- R6: A faulted result leaves as the corrupted product XORed with the mask. The corrupted product is the true product XOR (x^(flt_bit+M-1-flt_stage) mod the field polynomial).
- R7: While `rst` is high, and on the cycle after it, `prod_vld`, `err_out` and `prod_out` are all zero.
- R8: The mask is a Galois LFSR state: next = {s[M-2:0],0} XOR (s[M-1] ? 8'h1D : 0), seed 8'h01. It steps on every rising edge when `rst` is low. A masked output uses the state held just before the edge that registers it. The state is never zero and changes every cycle.
- R9: With `flt_en` low, the values on `flt_stage` and `flt_bit` have no effect on the product or on `err_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operands valid; begins an operation |
| a_in | input | M | First field operand |
| b_in | input | M | Second field operand, consumed MSB first |
| flt_en | input | 1 | Test-only fault enable |
| flt_stage | input | SW | Cell index that receives the fault |
| flt_bit | input | SW | Accumulator bit flipped by the fault |
| prod_out | output | M | Product, masked when an error is detected |
| prod_vld | output | 1 | Result valid strobe |
| err_out | output | 1 | Parity mismatch flag for this result |

## Verification
The bench builds the block with its defaults: M = 8, field polynomial 8'h1B, generator taps 8'h1D and seed 8'h01. At this width all 64 pairs of cell and bit can be driven through the fault port one operation at a time, so fault coverage is checked exhaustively rather than sampled. The known 8'h57 times 8'h83 product anchors the reduction polynomial. Because the register is only eight bits wide, the mask sequence can be followed edge by edge against a model built from the tap constant.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
  // Index width for selecting one of n items (at least 1 bit).
  function automatic int sel_w(input int n);
    int w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction
endpackage

// File: rtl/gfm_cell.sv
// One shift-reduce-accumulate step with parity prediction, registered.
module gfm_cell #(
  parameter int          M    = 8,
  parameter logic [M-1:0] POLY = 8'h1B,
  parameter int          IDX  = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         i_vld,
  input  logic [M-1:0] i_a,
  input  logic [M-1:0] i_b,
  input  logic [M-1:0] i_acc,
  input  logic         i_pp,
  input  logic         i_ap,
  input  logic         f_hit,
  input  logic [M-1:0] f_mask,
  output logic         o_vld,
  output logic [M-1:0] o_a,
  output logic [M-1:0] o_b,
  output logic [M-1:0] o_acc,
  output logic         o_pp,
  output logic         o_ap
);
  localparam int   BSEL    = M - 1 - IDX;
  // Dropping the top bit flips parity once; adding POLY flips it by its weight.
  localparam logic RED_FLIP = ~(^POLY);

  logic         msb, bbit, npp;
  logic [M-1:0] shifted, nxt;

  always_comb begin
    msb     = i_acc[M-1];
    bbit    = i_b[BSEL];
    shifted = {i_acc[M-2:0], 1'b0} ^ (msb ? POLY : '0);
    nxt     = shifted ^ (bbit ? i_a : '0) ^ (f_hit ? f_mask : '0);
    npp     = i_pp ^ (msb & RED_FLIP) ^ (bbit & i_ap);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld <= 1'b0;
      o_a   <= '0;
      o_b   <= '0;
      o_acc <= '0;
      o_pp  <= 1'b0;
      o_ap  <= 1'b0;
    end else begin
      o_vld <= i_vld;
      o_a   <= i_a;
      o_b   <= i_b;
      o_acc <= nxt;
      o_pp  <= npp;
      o_ap  <= i_ap;
    end
  end
endmodule

// File: rtl/gfm_lfsr.sv
// Free-running Galois shift-register mask source.
module gfm_lfsr #(
  parameter int           M    = 8,
  parameter logic [M-1:0] TAPS = 8'h1D,
  parameter logic [M-1:0] SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rst,
  output logic [M-1:0] state
);
  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else     state <= {state[M-2:0], 1'b0} ^ (state[M-1] ? TAPS : '0);
  end
endmodule

// File: rtl/gfm_guard_out.sv
// Parity compare and masked output register.
module gfm_guard_out #(
  parameter int M = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld,
  input  logic [M-1:0] acc,
  input  logic         pp,
  input  logic [M-1:0] mask,
  output logic [M-1:0] prod_out,
  output logic         prod_vld,
  output logic         err_out
);
  logic mismatch;
  always_comb mismatch = (^acc) ^ pp;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_out <= '0;
      prod_vld <= 1'b0;
      err_out  <= 1'b0;
    end else begin
      prod_vld <= vld;
      err_out  <= vld & mismatch;
      if (vld) prod_out <= acc ^ (mismatch ? mask : '0);
    end
  end
endmodule

// File: rtl/gfm_guard_mul.sv
module gfm_guard_mul #(
  parameter int           M         = 8,
  parameter logic [M-1:0] POLY      = 8'h1B,
  parameter logic [M-1:0] LFSR_TAPS = 8'h1D,
  parameter logic [M-1:0] LFSR_SEED = 8'h01,
  localparam int          SW        = gfm_pkg::sel_w(M)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [M-1:0]  a_in,
  input  logic [M-1:0]  b_in,
  input  logic          flt_en,
  input  logic [SW-1:0] flt_stage,
  input  logic [SW-1:0] flt_bit,
  output logic [M-1:0]  prod_out,
  output logic          prod_vld,
  output logic          err_out
);
  localparam logic [M-1:0] ONE = {{(M-1){1'b0}}, 1'b1};

  // Input register stage
  logic         in_vld, in_ap;
  logic [M-1:0] in_a, in_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_vld <= 1'b0;
      in_a   <= '0;
      in_b   <= '0;
      in_ap  <= 1'b0;
    end else begin
      in_vld <= start;
      in_a   <= a_in;
      in_b   <= b_in;
      in_ap  <= ^a_in;
    end
  end

  // Cell outputs, index k = output of cell k-1
  logic         st_vld [1:M];
  logic [M-1:0] st_a   [1:M];
  logic [M-1:0] st_b   [1:M];
  logic [M-1:0] st_acc [1:M];
  logic         st_pp  [1:M];
  logic         st_ap  [1:M];

  logic [M-1:0] flt_onehot;
  always_comb flt_onehot = ONE << flt_bit;

  for (genvar k = 0; k < M; k++) begin : g_cell
    logic         cv, cpp, cap, hit;
    logic [M-1:0] ca, cb, cacc;

    if (k == 0) begin : g_first
      assign cv   = in_vld;
      assign ca   = in_a;
      assign cb   = in_b;
      assign cacc = '0;
      assign cpp  = 1'b0;
      assign cap  = in_ap;
    end else begin : g_next
      assign cv   = st_vld[k];
      assign ca   = st_a[k];
      assign cb   = st_b[k];
      assign cacc = st_acc[k];
      assign cpp  = st_pp[k];
      assign cap  = st_ap[k];
    end

    assign hit = flt_en && (flt_stage == SW'(k));

    gfm_cell #(.M(M), .POLY(POLY), .IDX(k)) u_cell (
      .clk(clk), .rst(rst),
      .i_vld(cv), .i_a(ca), .i_b(cb), .i_acc(cacc), .i_pp(cpp), .i_ap(cap),
      .f_hit(hit), .f_mask(flt_onehot),
      .o_vld(st_vld[k+1]), .o_a(st_a[k+1]), .o_b(st_b[k+1]),
      .o_acc(st_acc[k+1]), .o_pp(st_pp[k+1]), .o_ap(st_ap[k+1])
    );
  end

  logic [M-1:0] lfsr_q;
  gfm_lfsr #(.M(M), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .state(lfsr_q)
  );

  gfm_guard_out #(.M(M)) u_out (
    .clk(clk), .rst(rst),
    .vld(st_vld[M]), .acc(st_acc[M]), .pp(st_pp[M]), .mask(lfsr_q),
    .prod_out(prod_out), .prod_vld(prod_vld), .err_out(err_out)
  );
endmodule

// File: rtl/gfm_guard_mul_sva.sv
module gfm_guard_mul_sva #(
  parameter int M = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         flt_en,
  input logic [M-1:0] prod_out,
  input logic         prod_vld,
  input logic         err_out,
  input logic [M-1:0] lfsr_st
);
  logic [M+1:0] st_hist, fl_hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_hist <= '0;
      fl_hist <= '0;
    end else begin
      st_hist <= {st_hist[M:0], start};
      fl_hist <= {fl_hist[M:0], flt_en};
    end
  end

  // R3: valid strobe follows start by M+1 edges
  a_r3_vld_latency: assert property (@(posedge clk) disable iff (rst)
    prod_vld == st_hist[M+1]);

  // R3: error only with a valid result
  a_r3_err_needs_vld: assert property (@(posedge clk) disable iff (rst)
    err_out |-> prod_vld);

  // R2: no fault anywhere in the window means no error
  a_r2_clean_no_err: assert property (@(posedge clk) disable iff (rst)
    (prod_vld && fl_hist == '0) |-> !err_out);

  // R7: outputs cleared after reset
  a_r7_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!prod_vld && !err_out && prod_out == '0));

  // R8: mask source never zero
  a_r8_mask_nonzero: assert property (@(posedge clk) disable iff (rst)
    lfsr_st != '0);

  // R8: mask source changes every cycle
  a_r8_mask_steps: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> !$stable(lfsr_st));
endmodule

bind gfm_guard_mul gfm_guard_mul_sva #(.M(M)) u_sva (
  .clk(clk), .rst(rst), .start(start), .flt_en(flt_en),
  .prod_out(prod_out), .prod_vld(prod_vld), .err_out(err_out),
  .lfsr_st(lfsr_q)
);

// File: tb/sim_gfm_guard_mul.sv
`timescale 1ns/1ps
module sim_gfm_guard_mul;
  localparam int          M    = 8;
  localparam int          SW   = 3;
  localparam int          LAT  = M + 1;
  localparam logic [M-1:0] POLY = 8'h1B;
  localparam logic [M-1:0] TAPS = 8'h1D;
  localparam logic [M-1:0] SEED = 8'h01;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [M-1:0]  a_in = '0, b_in = '0;
  logic          flt_en = 1'b0;
  logic [SW-1:0] flt_stage = '0, flt_bit = '0;
  logic [M-1:0]  prod_out;
  logic          prod_vld, err_out;

  always #2.5 clk = ~clk;

  gfm_guard_mul u0 (
    .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
    .flt_en(flt_en), .flt_stage(flt_stage), .flt_bit(flt_bit),
    .prod_out(prod_out), .prod_vld(prod_vld), .err_out(err_out)
  );

  typedef struct packed {
    logic [M-1:0] raw;
    logic         err;
    logic [1:0]   tag;   // 0 plain, 1 stream, 2 fault-disabled
    logic [31:0]  issue;
  } item_t;

  item_t        sb[$];
  int           total = 0, bad = 0;
  logic [31:0]  cyc = 0;
  logic [M-1:0] mdl = SEED, mdl_prev = SEED;
  bit           done = 0;

  function automatic logic [M-1:0] xt(input logic [M-1:0] v);
    return {v[M-2:0], 1'b0} ^ (v[M-1] ? POLY : '0);
  endfunction

  function automatic logic [M-1:0] gmul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] r;
    r = '0;
    for (int i = M - 1; i >= 0; i--) r = xt(r) ^ (b[i] ? a : '0);
    return r;
  endfunction

  function automatic logic [M-1:0] xpow(input int n);
    logic [M-1:0] r;
    r = 1;
    for (int i = 0; i < n; i++) r = xt(r);
    return r;
  endfunction

  // R8 mask model from the stated tap constant
  always @(posedge clk) begin
    cyc      <= cyc + 1;
    mdl_prev <= mdl;
    mdl      <= rst ? SEED : ({mdl[M-2:0], 1'b0} ^ (mdl[M-1] ? TAPS : '0));
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [M-1:0] a, input logic [M-1:0] b, input bit fe,
                       input int fs, input int fb, input logic [1:0] tag);
    item_t it;
    @(negedge clk);
    a_in = a; b_in = b; start = 1'b1;
    flt_en = fe; flt_stage = SW'(fs); flt_bit = SW'(fb);
    it.raw = gmul(a, b);
    if (fe) it.raw ^= xpow(fb + M - 1 - fs);
    it.err = fe;
    it.tag = tag;
    it.issue = cyc + 1;
    sb.push_back(it);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst && prod_vld) begin
      if (sb.size() == 0) chk(0, "R3 unexpected vld", 1, 0);
      else begin
        item_t it;
        logic [M-1:0] ex;
        it = sb.pop_front();
        ex = it.raw ^ (it.err ? mdl_prev : '0);
        if (it.err) begin
          chk(prod_out == ex, "R6 masked faulty product", prod_out, ex);
          chk(err_out == 1'b1, "R5 fault flagged", err_out, 1);
          chk(mdl_prev != '0, "R8 mask nonzero", mdl_prev, 1);
        end else begin
          chk(prod_out == ex, it.tag == 1 ? "R4 stream product" :
                              it.tag == 2 ? "R9 disabled fault product" : "R1 product",
              prod_out, ex);
          chk(err_out == 1'b0, it.tag == 2 ? "R9 no err" : "R2 no err", err_out, 0);
        end
        chk(cyc - it.issue == LAT, "R3 latency", cyc - it.issue, LAT);
      end
    end
    if (!rst && !prod_vld) chk(err_out == 1'b0, "R3 err without vld", err_out, 0);
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(prod_vld == 0, "R7 vld in reset", prod_vld, 0);
    chk(err_out == 0, "R7 err in reset", err_out, 0);
    chk(prod_out == 0, "R7 out in reset", prod_out, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(prod_vld == 0 && err_out == 0 && prod_out == 0, "R7 after reset", prod_out, 0);

    // R1 known value and edge operands
    drive(8'h57, 8'h83, 0, 0, 0, 0);
    drive(8'h00, 8'hFF, 0, 0, 0, 0);
    drive(8'hFF, 8'hFF, 0, 0, 0, 0);
    drive(8'h01, 8'hA5, 0, 0, 0, 0);
    drive(8'h80, 8'h80, 0, 0, 0, 0);
    @(negedge clk); start = 1'b0;
    repeat (LAT + 2) @(negedge clk);
    chk(gmul(8'h57, 8'h83) == 8'hC1, "R1 reference anchor", gmul(8'h57, 8'h83), 8'hC1);

    // R4 back-to-back stream
    for (int i = 0; i < 40; i++) drive(M'($urandom), M'($urandom), 0, 0, 0, 1);
    @(negedge clk); start = 1'b0;
    repeat (LAT + 2) @(negedge clk);

    // R9 selectors set while fault disabled
    for (int i = 0; i < 6; i++) drive(M'($urandom), M'($urandom), 0, i, 7 - i, 2);
    @(negedge clk); start = 1'b0;
    repeat (LAT + 2) @(negedge clk);

    // R5 R6 R8 every cell and bit, one isolated operation each
    for (int s = 0; s < M; s++) begin
      for (int j = 0; j < M; j++) begin
        drive(M'($urandom), M'($urandom), 1, s, j, 0);
        @(negedge clk); start = 1'b0;
        repeat (LAT + 2) @(negedge clk);
        flt_en = 1'b0;
      end
    end

    // Clean operations after faults
    for (int i = 0; i < 4; i++) drive(M'($urandom), M'($urandom), 0, 0, 0, 0);
    @(negedge clk); start = 1'b0;
    repeat (LAT + 3) @(negedge clk);
    chk(sb.size() == 0, "R3 all results returned", sb.size(), 0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R3 watchdog act=timeout exp=finish");
      summary();
      $finish;
    end
  end
endmodule